// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic core for filter loops on a small 16-bit controller. Each strobed operation takes two signed 16-bit fractional operands (Q15). The multiply path turns them into a Q31 product, and that product is added into a 36-bit accumulator. The accumulator holds 4 guard bits above the 32-bit fractional range. The other operations clear or load the accumulator, add a 16-bit or 32-bit word into it, shift it arithmetically by one place, or move its upper word to a 16-bit read register, either truncated or rounded.

Two sticky status flags report overflow. The extension flag reports that a result left the 32-bit fractional range. The sign flag reports that a result overflowed the full 36-bit accumulator. A mode input turns on saturation, which clamps out-of-range results instead of letting them wrap.

Two index registers follow the coefficient and sample pointers of a filter. They advance on every multiply-accumulate and wrap inside circular buffers. Each index has its own mask that selects which of its bits take part in the wrap. Every operation takes effect on the first rising clock edge at which `valid_i` is high.

Top module: `frac_mac`

## Requirements
- R1: With op_i=3 (multiply-accumulate), the accumulator gains 2*a*b, where a and b are the signed 16-bit operands. The product is sign-extended to 36 bits.
- R2: The single operand pair a=b=-32768 contributes 0x7FFFFFFF, the largest positive Q31 value, and does not overflow.
- R3: ev_o is set when an arithmetic result (op_i 3, 4, 5, 6 or 7) lies outside the signed 32-bit range. Once set, it stays set until op_i=1 or op_i=2.
- R4: mv_o is set when the exact result of an arithmetic operation lies outside the signed 36-bit range. With saturation off, the accumulator then holds that result wrapped to 36 bits. mv_o is sticky and is cleared only by op_i 1 or 2.
- R5: With sat_en_i=1, an arithmetic result outside the signed 32-bit range is replaced by 0x7FFFFFFF or by -0x80000000 (sign-extended), according to the sign of the exact result. The flags are still set as in R3 and R4.
- R6: op_i=1 sets the accumulator to zero, and op_i=2 loads it with the sign-extended 32-bit word {a_i,b_i}. Both clear ev_o and mv_o.
- R7: op_i=4 adds a_i, sign-extended, at accumulator bits 31:16. op_i=5 adds the sign-extended word {a_i,b_i}. op_i=6 multiplies the accumulator by two. op_i=7 halves it and rounds toward minus infinity.
- R8: op_i=9 loads rd_o with accumulator bits 31:16. op_i=8 loads rd_o with those bits plus bit 15. With saturation off, the rounded value wraps at 16 bits. With sat_en_i=1, an accumulator outside the 32-bit range is first clamped as in R5, and a rounded value that would pass 0x7FFF stays at 0x7FFF. Neither operation changes the accumulator.
- R9: op_i=11 loads the X and Y masks from a_i and b_i. The masks reset to all ones. op_i=10 loads the X and Y indices from a_i and b_i. On every op_i=3, each index becomes (idx & ~mask) | ((idx + 2) & mask).
- R10: When valid_i is low, or op_i is 0 or 12 to 15, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand / upper word |
| b_i | input | 16 | Second operand / lower word |
| sat_en_i | input | 1 | Saturation mode |
| acc_o | output | 36 | Accumulator |
| rd_o | output | 16 | Read register (rounded or truncated) |
| ev_o | output | 1 | Sticky extension overflow |
| mv_o | output | 1 | Sticky 36-bit overflow |
| x_idx_o | output | 16 | X circular index |
| y_idx_o | output | 16 | Y circular index |

## Verification
A sweep over a grid of operand values that includes both extremes checks every product against 2*a*b. A multiplier that does not special-case -1 x -1 would show up here as a product of -1.0 instead of almost +1.0.

Long positive runs of multiply-accumulate push the accumulator past 32 bits and then past 36 bits. If either flag were wired to the wrong bit, or were not sticky, it would clear or fire too early. If the wrap were wrong, the accumulator value would be wrong after the run.

The saturation runs in both directions catch a clamp to the wrong extreme and a clamp that misses a shift overflow. The read tests target the rounding carry at 0x7FFF8000, where an unsaturated rounder would return 0x8000 in saturation mode. They also read an accumulator outside the 32-bit range with saturation on.

The mask test drives each index across its wrap boundary. An index unit that let the carry reach the unmasked bits would change the upper address.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_LOAD = 4'd2,
    OP_MAC  = 4'd3,
    OP_ADDW = 4'd4,
    OP_ADDL = 4'd5,
    OP_ASL  = 4'd6,
    OP_ASR  = 4'd7,
    OP_RDR  = 4'd8,
    OP_RDT  = 4'd9,
    OP_SIDX = 4'd10,
    OP_SMSK = 4'd11
  } mac_op_e;
endpackage

// File: rtl/frac_mac_mul.sv
module frac_mac_mul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] q_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic                 both_min;

  assign prod     = $signed(a_i) * $signed(b_i);
  assign both_min = (a_i == {1'b1, {(DW-1){1'b0}}}) && (b_i == {1'b1, {(DW-1){1'b0}}});

  // -1 x -1 maps to the largest Q31 value instead of wrapping to -1
  always_comb begin
    if (both_min) q_o = {1'b0, {(PW-1){1'b1}}};
    else          q_o = {prod[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/frac_mac_acc.sv
module frac_mac_acc
  import frac_mac_pkg::*;
#(
  parameter int DW = 16,
  parameter int GW = 4,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  mac_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [PW-1:0] prod_i,
  input  logic          sat_en_i,
  output logic [AW-1:0] acc_o,
  output logic [DW-1:0] rd_o,
  output logic          ev_o,
  output logic          mv_o
);
  localparam int EW = AW + 1;

  logic [AW-1:0] acc_q, acc_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          ev_q, mv_q;
  logic [EW-1:0] res, acc_x;
  logic          arith, ev_set, mv_set;
  logic [AW-1:0] clamp;
  logic          in32;
  logic [PW-1:0] c32, src;
  logic [DW-1:0] hi, rnd;

  assign acc_x = {acc_q[AW-1], acc_q};

  // one extra bit above the accumulator keeps the exact sign of every result
  always_comb begin
    arith = 1'b1;
    res   = '0;
    unique case (op_i)
      OP_MAC:  res = acc_x + {{(EW-PW){prod_i[PW-1]}}, prod_i};
      OP_ADDW: res = acc_x + {{(EW-PW){a_i[DW-1]}}, a_i, {DW{1'b0}}};
      OP_ADDL: res = acc_x + {{(EW-PW){a_i[DW-1]}}, a_i, b_i};
      OP_ASL:  res = {acc_q, 1'b0};
      OP_ASR:  res = {acc_q[AW-1], acc_q[AW-1], acc_q[AW-1:1]};
      default: arith = 1'b0;
    endcase
  end

  assign ev_set = arith && !((&res[EW-1:PW-1]) || !(|res[EW-1:PW-1]));
  assign mv_set = arith && (res[EW-1] ^ res[EW-2]);
  assign clamp  = res[EW-1] ? {{(GW+1){1'b1}}, {(PW-1){1'b0}}}
                            : {{(GW+1){1'b0}}, {(PW-1){1'b1}}};

  // read path
  assign in32 = (&acc_q[AW-1:PW-1]) || !(|acc_q[AW-1:PW-1]);
  assign c32  = in32 ? acc_q[PW-1:0]
                     : (acc_q[AW-1] ? {1'b1, {(PW-1){1'b0}}} : {1'b0, {(PW-1){1'b1}}});
  assign src  = sat_en_i ? c32 : acc_q[PW-1:0];
  assign hi   = src[PW-1:DW];

  always_comb begin
    rnd = hi + {{(DW-1){1'b0}}, src[DW-1]};
    if (sat_en_i && src[DW-1] && (hi == {1'b0, {(DW-1){1'b1}}})) rnd = hi;
  end

  always_comb begin
    acc_d = acc_q;
    rd_d  = rd_q;
    if (arith) acc_d = (sat_en_i && ev_set) ? clamp : res[AW-1:0];
    unique case (op_i)
      OP_CLR:  acc_d = '0;
      OP_LOAD: acc_d = {{GW{a_i[DW-1]}}, a_i, b_i};
      OP_RDR:  rd_d  = rnd;
      OP_RDT:  rd_d  = hi;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rd_q  <= '0;
      ev_q  <= 1'b0;
      mv_q  <= 1'b0;
    end else if (valid_i) begin
      acc_q <= acc_d;
      rd_q  <= rd_d;
      if (op_i == OP_CLR || op_i == OP_LOAD) begin
        ev_q <= 1'b0;
        mv_q <= 1'b0;
      end else begin
        ev_q <= ev_q | ev_set | mv_set;
        mv_q <= mv_q | mv_set;
      end
    end
  end

  assign acc_o = acc_q;
  assign rd_o  = rd_q;
  assign ev_o  = ev_q;
  assign mv_o  = mv_q;

  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CLR |=> acc_q == '0 && !ev_q && !mv_q);
  a_r3_ev_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q && !(valid_i && (op_i == OP_CLR || op_i == OP_LOAD)) |=> ev_q);
  a_r4_mv_implies_ev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_q |-> ev_q);
  a_r5_sat_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_en_i && (op_i inside {OP_MAC, OP_ADDW, OP_ADDL, OP_ASL, OP_ASR})
    |=> ((&acc_q[AW-1:PW-1]) || !(|acc_q[AW-1:PW-1])));
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q) && $stable(rd_q) && $stable(ev_q) && $stable(mv_q));
  a_r8_read_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_RDR || op_i == OP_RDT) |=> $stable(acc_q));
endmodule

// File: rtl/frac_mac_idx.sv
module frac_mac_idx
  import frac_mac_pkg::*;
#(
  parameter int IW   = 16,
  parameter int STEP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  mac_op_e       op_i,
  input  logic [IW-1:0] val_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q, mask_q, inc;

  assign inc = idx_q + IW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mask_q <= '1;
    end else if (valid_i) begin
      unique case (op_i)
        OP_SIDX: idx_q  <= val_i;
        OP_SMSK: mask_q <= val_i;
        // masked bits count and wrap, the rest stay fixed
        OP_MAC:  idx_q  <= (idx_q & ~mask_q) | (inc & mask_q);
        default: ;
      endcase
    end
  end

  assign idx_o = idx_q;

  a_r9_upper_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MAC |=> ((idx_q & ~mask_q) == ($past(idx_q) & ~$past(mask_q))));
  a_r10_idx_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(idx_q) && $stable(mask_q));
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int DW       = 16,
  parameter int GW       = 4,
  parameter int IW       = 16,
  parameter int IDX_STEP = 2,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sat_en_i,
  output logic [AW-1:0] acc_o,
  output logic [DW-1:0] rd_o,
  output logic          ev_o,
  output logic          mv_o,
  output logic [IW-1:0] x_idx_o,
  output logic [IW-1:0] y_idx_o
);
  mac_op_e       op;
  logic [PW-1:0] prod;
  logic [IW-1:0] idx_val [2];
  logic [IW-1:0] idx_out [2];

  assign op = mac_op_e'(op_i);

  frac_mac_mul #(.DW(DW)) u_mul (
    .a_i (a_i),
    .b_i (b_i),
    .q_o (prod)
  );

  frac_mac_acc #(.DW(DW), .GW(GW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .op_i     (op),
    .a_i      (a_i),
    .b_i      (b_i),
    .prod_i   (prod),
    .sat_en_i (sat_en_i),
    .acc_o    (acc_o),
    .rd_o     (rd_o),
    .ev_o     (ev_o),
    .mv_o     (mv_o)
  );

  assign idx_val[0] = IW'(a_i);
  assign idx_val[1] = IW'(b_i);

  for (genvar g = 0; g < 2; g++) begin : g_idx
    frac_mac_idx #(.IW(IW), .STEP(IDX_STEP)) u_idx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .op_i    (op),
      .val_i   (idx_val[g]),
      .idx_o   (idx_out[g])
    );
  end

  assign x_idx_o = idx_out[0];
  assign y_idx_o = idx_out[1];

  a_r2_min_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_CLR ##1 valid_i && op == OP_MAC && a_i == 16'h8000 && b_i == 16'h8000
    |=> acc_o == AW'(32'h7FFF_FFFF) && !ev_o);
endmodule

// File: tb/frac_mac_tb_top.sv
`timescale 1ns/1ps
module frac_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic        sat = 1'b0;
  logic [35:0] acc;
  logic [15:0] rd, xi, yi;
  logic        ev, mv;

  int checks = 0, errors = 0;

  longint m_acc = 0;
  logic   m_ev = 0, m_mv = 0;
  logic [15:0] m_rd = 0, m_x = 0, m_y = 0, m_xm = 16'hFFFF, m_ym = 16'hFFFF;

  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;
  localparam longint LIM36 = 64'sd34359738368;

  always #2.5 clk = ~clk;

  frac_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .sat_en_i(sat), .acc_o(acc), .rd_o(rd), .ev_o(ev), .mv_o(mv),
    .x_idx_o(xi), .y_idx_o(yi)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint wrap36(input longint r);
    logic [63:0] u;
    u = r;
    return longint'({{28{u[35]}}, u[35:0]});
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] i, input logic [15:0] m);
    return (i & ~m) | ((i + 16'd2) & m);
  endfunction

  task automatic model(input logic [3:0] o, input logic [15:0] va, input logic [15:0] vb);
    longint r, sa, sb, c;
    logic   ar, e, v;
    logic [15:0] h;
    logic   hb;
    sa = longint'($signed(va));
    sb = longint'($signed(vb));
    ar = 1'b1;
    r  = m_acc;
    case (o)
      4'd3: r = m_acc + ((va == 16'h8000 && vb == 16'h8000) ? MAX32 : 2 * sa * sb);
      4'd4: r = m_acc + sa * 65536;
      4'd5: r = m_acc + longint'($signed({va, vb}));
      4'd6: r = m_acc * 2;
      4'd7: r = m_acc >>> 1;
      default: ar = 1'b0;
    endcase
    if (ar) begin
      e = (r > MAX32) || (r < MIN32);
      v = (r >= LIM36) || (r < -LIM36);
      if (sat && e) m_acc = (r < 0) ? MIN32 : MAX32;
      else          m_acc = wrap36(r);
      m_ev = m_ev | e;
      m_mv = m_mv | v;
    end
    case (o)
      4'd1: begin m_acc = 0; m_ev = 0; m_mv = 0; end
      4'd2: begin m_acc = longint'($signed({va, vb})); m_ev = 0; m_mv = 0; end
      4'd8, 4'd9: begin
        c = m_acc;
        if (sat) c = (m_acc > MAX32) ? MAX32 : (m_acc < MIN32) ? MIN32 : m_acc;
        h  = c[31:16];
        hb = c[15];
        if (o == 4'd9) m_rd = h;
        else if (sat && h == 16'h7FFF && hb) m_rd = h;
        else m_rd = h + {15'd0, hb};
      end
      4'd10: begin m_x = va; m_y = vb; end
      4'd11: begin m_xm = va; m_ym = vb; end
      default: ;
    endcase
    if (o == 4'd3) begin m_x = nxt(m_x, m_xm); m_y = nxt(m_y, m_ym); end
  endtask

  task automatic compare(input string tag);
    logic [63:0] ea;
    ea = m_acc;
    chk(acc == ea[35:0], {tag, " acc"}, 64'(acc), 64'(ea[35:0]));
    chk({ev, mv} == {m_ev, m_mv}, {tag, " flags ev,mv"}, 64'({ev, mv}), 64'({m_ev, m_mv}));
    chk(rd == m_rd, {tag, " rd"}, 64'(rd), 64'(m_rd));
    chk({xi, yi} == {m_x, m_y}, {tag, " idx"}, 64'({xi, yi}), 64'({m_x, m_y}));
  endtask

  task automatic do_op(input logic [3:0] o, input logic [15:0] va, input logic [15:0] vb, input string tag);
    @(negedge clk);
    valid = 1'b1; op = o; a = va; b = vb;
    @(posedge clk);
    model(o, va, vb);
    @(negedge clk);
    valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle_op(input logic [3:0] o, input string tag);
    @(negedge clk);
    valid = 1'b0; op = o; a = 16'h7FFF; b = 16'h7FFF;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R6 reset");

    // R1 R2: product sweep incl. both extremes
    for (int i = 0; i < 17; i++) begin
      for (int j = 0; j < 17; j++) begin
        logic [15:0] va, vb;
        va = (i == 16) ? 16'h7FFF : 16'(-32768 + i * 4096);
        vb = (j == 16) ? 16'h7FFF : 16'(-32768 + j * 4096);
        do_op(4'd1, 0, 0, "R6 clear");
        do_op(4'd3, va, vb, "R1 product");
      end
    end
    do_op(4'd1, 0, 0, "R6 clear");
    do_op(4'd3, 16'h8000, 16'h8000, "R2 min x min");
    do_op(4'd3, 16'h8000, 16'h8000, "R2 min x min twice R3");

    // R3 R4: growth past 32 and 36 bits, wrapping
    do_op(4'd1, 0, 0, "R6 clear");
    for (int k = 0; k < 20; k++) do_op(4'd3, 16'h7FFF, 16'h7FFF, "R3 R4 accumulate");
    do_op(4'd3, 16'h0001, 16'h0001, "R3 R4 sticky");
    do_op(4'd2, 16'h0000, 16'h0005, "R6 load clears flags");

    // R5 saturation both ways
    sat = 1'b1;
    do_op(4'd1, 0, 0, "R6 clear");
    for (int k = 0; k < 3; k++) do_op(4'd3, 16'h7FFF, 16'h7FFF, "R5 sat positive");
    do_op(4'd1, 0, 0, "R6 clear");
    for (int k = 0; k < 3; k++) do_op(4'd3, 16'h7FFF, 16'h8000, "R5 sat negative");
    do_op(4'd2, 16'h4000, 16'h0001, "R6 load");
    do_op(4'd6, 0, 0, "R5 sat shift");
    do_op(4'd5, 16'h8000, 16'h0000, "R5 R7 addl");
    do_op(4'd5, 16'h8000, 16'h0000, "R5 sat addl negative");
    do_op(4'd7, 0, 0, "R7 asr sat");

    // R7 R8 word ops and reads in both modes
    for (int s = 0; s < 2; s++) begin
      sat = s[0];
      do_op(4'd2, 16'h1234, 16'h8000, "R6 load");
      do_op(4'd8, 0, 0, "R8 rounded");
      do_op(4'd9, 0, 0, "R8 truncated");
      do_op(4'd2, 16'h7FFF, 16'h8000, "R6 load");
      do_op(4'd8, 0, 0, "R8 rounding at top");
      do_op(4'd2, 16'hFFFF, 16'h7FFF, "R6 load");
      do_op(4'd8, 0, 0, "R8 rounded negative");
      do_op(4'd9, 0, 0, "R8 truncated negative");
      do_op(4'd4, 16'hFFF0, 0, "R7 addw");
      do_op(4'd5, 16'h0001, 16'h2345, "R7 addl");
      do_op(4'd7, 0, 0, "R7 asr");
      do_op(4'd6, 0, 0, "R7 asl");
      do_op(4'd2, 16'hFFFF, 16'hFFFF, "R6 load");
      do_op(4'd7, 0, 0, "R7 asr of -1");
    end
    sat = 1'b0;
    do_op(4'd2, 16'h7FFF, 16'hFFFF, "R6 load");
    do_op(4'd6, 0, 0, "R3 asl out of range");
    sat = 1'b1;
    do_op(4'd8, 0, 0, "R8 read clamped");
    do_op(4'd9, 0, 0, "R8 read clamped trunc");
    sat = 1'b0;
    do_op(4'd8, 0, 0, "R8 read wrapped");

    // R9 circular indices
    do_op(4'd11, 16'h000F, 16'h0007, "R9 masks");
    do_op(4'd10, 16'h1234, 16'h5670, "R9 index load");
    for (int k = 0; k < 10; k++) do_op(4'd3, 16'h0100, 16'h0100, "R9 index step");
    do_op(4'd11, 16'hFFFF, 16'hFFFF, "R9 masks linear");
    do_op(4'd10, 16'hFFFE, 16'h0000, "R9 index load");
    do_op(4'd3, 0, 0, "R9 linear wrap");

    // R10 ignored strobes and codes
    idle_op(4'd3, "R10 valid low mac");
    idle_op(4'd1, "R10 valid low clear");
    do_op(4'd0, 16'h7FFF, 16'h7FFF, "R10 nop");
    for (int c = 12; c < 16; c++) do_op(4'(c), 16'h7FFF, 16'h7FFF, "R10 unused code");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule